// File: doc/BRIEF.md
# Twelve-Channel DMA Request Arbiter

This block decides which of twelve DMA channels may run its next transfer. Each channel has an enable and a two-bit source select. The source select names where the channel's request comes from: a line from outside the chip, a line from an on-chip peripheral, or a request the channel raises itself. Only some channel numbers may use each source. A channel that names a source its number does not allow never counts as requesting. The qualified requests then go to a picker. The picker works either in fixed order, where the lowest channel number wins, or in rotating order, where the search starts just after the channel that won last. A mode input chooses the order, and it may change at any time.

A winner is registered as a one-hot grant together with its channel index. The grant stays in place until the granted channel pulses its done line. The transfer engine decides what "done" means: one transfer unit when it steals cycles, or the whole count when it runs a burst. After a release, the grant stays empty for one cycle. The arbiter then picks again from the requests present in that cycle.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant_o` is all zero, `grant_vld_o` is 0 and `grant_idx_o` is 0. The rotation pointer starts at channel 11, so in rotating mode channel 0 ranks first in the first arbitration.
- R2: A channel is eligible only while its enable bit is 1. With source code 2'b00 (self request, at bits [2i+1:2i] of `src_sel_i`), channel i is eligible when `auto_req_i[i]` is 1. This works on any channel 0 to 11.
- R3: Source code 2'b01 (external line) makes channel i eligible through `ext_req_i[i]` only for channels 0 to 3. On channels 4 to 11 this code leaves the channel never eligible, whatever the other request inputs are.
- R4: Source code 2'b10 (peripheral line) makes channel i eligible through `peri_req_i[i]` only for channels 0 to 5. On channels 6 to 11 this code leaves the channel never eligible.
- R5: Source code 2'b11 leaves a channel never eligible on every channel.
- R6: With `rr_mode_i` = 0 (fixed order), the eligible channel with the lowest number wins.
- R7: With `rr_mode_i` = 1 (rotating order), the winner is the first eligible channel found by counting upward from the channel granted most recently, wrapping from 11 to 0. The most recent winner ranks last. The pointer moves on every new grant in both modes.
- R8: When no grant is held and at least one channel is eligible, the winner is shown at the next clock edge. `grant_o` has only the winner's bit set, `grant_idx_o` holds its number and `grant_vld_o` is 1. `grant_o` is never more than one-hot.
- R9: A held grant stays unchanged until `done_i` of the granted channel is 1 at a clock edge. Request, enable, source, mode and other channels' done inputs have no effect on it meanwhile.
- R10: The edge that sees the granted channel's done clears the grant. The next arbitration uses the inputs of the following cycle, so a grant is never followed directly by another grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rr_mode_i | input | 1 | 0 = fixed order, 1 = rotating order |
| ch_en_i | input | 12 | Per-channel enable |
| src_sel_i | input | 24 | Per-channel source code, channel i at [2i+1:2i] |
| ext_req_i | input | 4 | External request lines, channels 0 to 3 |
| peri_req_i | input | 6 | Peripheral request lines, channels 0 to 5 |
| auto_req_i | input | 12 | Self request per channel |
| done_i | input | 12 | Per-channel release pulse for a held grant |
| grant_o | output | 12 | One-hot grant |
| grant_idx_o | output | 4 | Number of the granted channel |
| grant_vld_o | output | 1 | A grant is held |

## Verification
Directed patterns separate the three source codes from the forbidden code on channels just inside and just outside each allowed range (3 and 4 for the external line, 5 and 6 for the peripheral line). This shows that eligibility is tied to the channel number and not only to the code. Crowded request sets with all twelve channels ready are run in both orders. Fixed order keeps returning channel 0, while rotating order must walk through every channel in turn. That walk tells the pointer update apart from a plain lowest-number pick. Long random runs then mix done pulses on both granted and non-granted channels, together with mode flips while a grant is held. These runs show that only the owner's done releases the grant and that one empty cycle follows each release.

// File: rtl/dma_arb_pkg.sv
// Package: shared encodings for the DMA request arbiter.
// Assumes two-bit source codes per channel.
package dma_arb_pkg;
    typedef enum logic [1:0] {
        SRC_AUTO = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_PERI = 2'b10,
        SRC_OFF  = 2'b11
    } src_sel_e;
endpackage

// File: rtl/dma_req_qualify.sv
// Module: dma_req_qualify
// Turns raw request lines into one eligibility bit per channel.
// The external line exists only below EXT_CH and the peripheral line only
// below PERI_CH; any other code/channel pairing yields no request.
// Assumes EXT_CH <= NCH and PERI_CH <= NCH. Purely combinational.
module dma_req_qualify
    import dma_arb_pkg::*;
#(
    parameter int NCH     = 12,
    parameter int EXT_CH  = 4,
    parameter int PERI_CH = 6
) (
    input  logic [NCH-1:0]   ch_en_i,
    input  logic [2*NCH-1:0] src_sel_i,
    input  logic [EXT_CH-1:0]  ext_req_i,
    input  logic [PERI_CH-1:0] peri_req_i,
    input  logic [NCH-1:0]   auto_req_i,
    output logic [NCH-1:0]   elig_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ext_ok;
        logic peri_ok;
        src_sel_e code;
        assign code = src_sel_e'(src_sel_i[2*i +: 2]);

        if (i < EXT_CH) begin : g_ext
            assign ext_ok = ext_req_i[i];
        end else begin : g_noext
            assign ext_ok = 1'b0;
        end

        if (i < PERI_CH) begin : g_peri
            assign peri_ok = peri_req_i[i];
        end else begin : g_noperi
            assign peri_ok = 1'b0;
        end

        // Select the request line named by this channel's source code.
        always_comb begin
            unique case (code)
                SRC_AUTO: elig_o[i] = ch_en_i[i] & auto_req_i[i];
                SRC_EXT:  elig_o[i] = ch_en_i[i] & ext_ok;
                SRC_PERI: elig_o[i] = ch_en_i[i] & peri_ok;
                default:  elig_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dma_arb_pick.sv
// Module: dma_arb_pick
// Chooses one channel from an eligibility vector. Fixed order takes the
// lowest number; rotating order searches upward from last_i + 1 with wrap.
// Assumes last_i < NCH. Purely combinational.
module dma_arb_pick #(
    parameter int NCH  = 12,
    localparam int IDXW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  elig_i,
    input  logic            rr_mode_i,
    input  logic [IDXW-1:0] last_i,
    output logic            win_vld_o,
    output logic [IDXW-1:0] win_idx_o
);
    // Scan the candidates in the order the selected mode gives.
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        for (int k = 0; k < NCH; k++) begin
            int cand;
            if (rr_mode_i) begin
                cand = int'(last_i) + 1 + k;
                if (cand >= NCH) cand = cand - NCH;
            end else begin
                cand = k;
            end
            if (!win_vld_o && elig_i[cand]) begin
                win_vld_o = 1'b1;
                win_idx_o = IDXW'(cand);
            end
        end
    end
endmodule

// File: rtl/dma_grant_hold.sv
// Module: dma_grant_hold
// Holds the current grant and the rotation pointer. A winner is taken only
// when nothing is held; the owner's done pulse frees it. Assumes win_idx_i < NCH.
module dma_grant_hold #(
    parameter int NCH  = 12,
    localparam int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_vld_i,
    input  logic [IDXW-1:0] win_idx_i,
    input  logic [NCH-1:0]  done_i,
    output logic            held_o,
    output logic [IDXW-1:0] idx_o,
    output logic [IDXW-1:0] last_o
);
    // Take, keep or release the grant; move the pointer on each new grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= 1'b0;
            idx_o  <= '0;
            last_o <= IDXW'(NCH - 1);
        end else if (held_o) begin
            if (done_i[idx_o]) begin
                held_o <= 1'b0;
                idx_o  <= '0;
            end
        end else if (win_vld_i) begin
            held_o <= 1'b1;
            idx_o  <= win_idx_i;
            last_o <= win_idx_i;
        end
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
// Module: dma_prio_arbiter (top)
// Twelve-channel request arbiter: qualifies each request by source and
// channel number, picks in fixed or rotating order, and holds the grant
// until the owner reports done. Assumes synchronous active-low reset.
module dma_prio_arbiter #(
    parameter int NCH     = 12,
    parameter int EXT_CH  = 4,
    parameter int PERI_CH = 6,
    localparam int IDXW   = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rr_mode_i,
    input  logic [NCH-1:0]     ch_en_i,
    input  logic [2*NCH-1:0]   src_sel_i,
    input  logic [EXT_CH-1:0]  ext_req_i,
    input  logic [PERI_CH-1:0] peri_req_i,
    input  logic [NCH-1:0]     auto_req_i,
    input  logic [NCH-1:0]     done_i,
    output logic [NCH-1:0]     grant_o,
    output logic [IDXW-1:0]    grant_idx_o,
    output logic               grant_vld_o
);
    logic [NCH-1:0]  elig;
    logic            win_vld;
    logic [IDXW-1:0] win_idx;
    logic            held;
    logic [IDXW-1:0] held_idx;
    logic [IDXW-1:0] last_idx;

    dma_req_qualify #(.NCH(NCH), .EXT_CH(EXT_CH), .PERI_CH(PERI_CH)) qual_i (
        .ch_en_i    (ch_en_i),
        .src_sel_i  (src_sel_i),
        .ext_req_i  (ext_req_i),
        .peri_req_i (peri_req_i),
        .auto_req_i (auto_req_i),
        .elig_o     (elig)
    );

    dma_arb_pick #(.NCH(NCH)) pick_i (
        .elig_i    (elig),
        .rr_mode_i (rr_mode_i),
        .last_i    (last_idx),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx)
    );

    dma_grant_hold #(.NCH(NCH)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_vld_i (win_vld),
        .win_idx_i (win_idx),
        .done_i    (done_i),
        .held_o    (held),
        .idx_o     (held_idx),
        .last_o    (last_idx)
    );

    // Decode the held index into the one-hot grant vector.
    always_comb begin
        grant_o = '0;
        if (held) grant_o[held_idx] = 1'b1;
    end

    assign grant_idx_o = held_idx;
    assign grant_vld_o = held;
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
// Module: dma_prio_arbiter_chk
// Property checker for dma_prio_arbiter, attached through bind.
module dma_prio_arbiter_chk
    import dma_arb_pkg::*;
#(
    parameter int NCH     = 12,
    parameter int EXT_CH  = 4,
    parameter int PERI_CH = 6,
    localparam int IDXW   = $clog2(NCH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rr_mode_i,
    input logic [NCH-1:0]     ch_en_i,
    input logic [2*NCH-1:0]   src_sel_i,
    input logic [NCH-1:0]     auto_req_i,
    input logic [NCH-1:0]     done_i,
    input logic [NCH-1:0]     grant_o,
    input logic               grant_vld_o
);
    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (grant_vld_o == (grant_o != '0)));

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && (done_i & grant_o) == '0) |=> $stable(grant_o));

    // R10
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_i & grant_o) != '0) |=> (grant_o == '0));

    // R2
    grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0) |=> ((grant_o & ~$past(ch_en_i)) == '0));

    // R6
    fixed_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0 && !rr_mode_i && ch_en_i[0] && auto_req_i[0]
         && src_sel_i[1:0] == SRC_AUTO) |=> grant_o[0]);
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(
    .NCH(NCH), .EXT_CH(EXT_CH), .PERI_CH(PERI_CH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rr_mode_i   (rr_mode_i),
    .ch_en_i     (ch_en_i),
    .src_sel_i   (src_sel_i),
    .auto_req_i  (auto_req_i),
    .done_i      (done_i),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o)
);

// File: tb/dma_prio_arbiter_tb.sv
// Bench for dma_prio_arbiter: directed corner cases plus seeded random
// traffic, all compared cycle by cycle against a bench-side model.
module dma_prio_arbiter_tb_top;
    localparam int NCH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rr_mode_i = 1'b0;
    logic [11:0] ch_en_i = '0;
    logic [23:0] src_sel_i = '0;
    logic [3:0]  ext_req_i = '0;
    logic [5:0]  peri_req_i = '0;
    logic [11:0] auto_req_i = '0;
    logic [11:0] done_i = '0;
    logic [11:0] grant_o;
    logic [3:0]  grant_idx_o;
    logic        grant_vld_o;

    int n_cmp = 0;
    int n_bad = 0;
    int m_grant = -1;
    int m_last = 11;
    logic wd_hit = 1'b0;

    always #5 clk = ~clk;

    dma_prio_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .rr_mode_i(rr_mode_i), .ch_en_i(ch_en_i),
        .src_sel_i(src_sel_i), .ext_req_i(ext_req_i), .peri_req_i(peri_req_i),
        .auto_req_i(auto_req_i), .done_i(done_i), .grant_o(grant_o),
        .grant_idx_o(grant_idx_o), .grant_vld_o(grant_vld_o)
    );

    // Eligibility of one channel from the source rules.
    function automatic bit elig(int i);
        logic [1:0] c = src_sel_i[2*i +: 2];
        if (!ch_en_i[i]) return 0;
        case (c)
            2'b00: return auto_req_i[i];
            2'b01: return (i < 4) ? ext_req_i[i] : 1'b0;
            2'b10: return (i < 6) ? peri_req_i[i] : 1'b0;
            default: return 0;
        endcase
    endfunction

    // Winner under the current mode, or -1.
    function automatic int pick();
        for (int k = 0; k < NCH; k++) begin
            int c = rr_mode_i ? (m_last + 1 + k) % NCH : k;
            if (elig(c)) return c;
        end
        return -1;
    endfunction

    // Advance the model by one edge using the inputs now applied.
    task automatic model_step();
        if (m_grant >= 0) begin
            if (done_i[m_grant]) m_grant = -1;
        end else begin
            int w = pick();
            if (w >= 0) begin
                m_grant = w;
                m_last = w;
            end
        end
    endtask

    task automatic compare(string tag);
        logic [11:0] eg = (m_grant >= 0) ? (12'b1 << m_grant) : 12'b0;
        logic [3:0]  ei = (m_grant >= 0) ? 4'(m_grant) : 4'd0;
        n_cmp++;
        if (grant_o !== eg || grant_idx_o !== ei || grant_vld_o !== (m_grant >= 0)) begin
            n_bad++;
            $display("FAIL %s: grant=%h idx=%0d vld=%b expected grant=%h idx=%0d vld=%b",
                     tag, grant_o, grant_idx_o, grant_vld_o, eg, ei, m_grant >= 0);
        end
    endtask

    // One cycle: inputs are already set; model, clock, compare at negedge.
    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic quiet();
        ch_en_i = '0; src_sel_i = '0; ext_req_i = '0; peri_req_i = '0;
        auto_req_i = '0; done_i = '0;
    endtask

    // Release any held grant and leave the arbiter idle.
    task automatic drain(string tag);
        quiet();
        done_i = '1;
        cyc(tag);
        cyc(tag);
        done_i = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // R1: first rotating arbitration favours channel 0 with all ready
        rr_mode_i = 1'b1; ch_en_i = '1; auto_req_i = '1;
        cyc("R1");
        drain("R10");

        // R3: external code on channel 4 never requests, channel 3 does
        ch_en_i = '1; src_sel_i[9:8] = 2'b01; ext_req_i = '1; peri_req_i = '1; auto_req_i = '1;
        rr_mode_i = 1'b0;
        for (int i = 0; i < 12; i++) if (i != 4) ch_en_i[i] = 1'b0;
        cyc("R3"); cyc("R3");
        ch_en_i[3] = 1'b1; src_sel_i[7:6] = 2'b01;
        cyc("R3");
        drain("R10");

        // R4: peripheral code on channel 6 never requests, channel 5 does
        ch_en_i = 12'h040; src_sel_i[13:12] = 2'b10; peri_req_i = '1; auto_req_i = '1; ext_req_i = '1;
        cyc("R4"); cyc("R4");
        ch_en_i[5] = 1'b1; src_sel_i[11:10] = 2'b10;
        cyc("R4");
        drain("R10");

        // R5: code 11 on every channel, everything requesting
        ch_en_i = '1; src_sel_i = '1; ext_req_i = '1; peri_req_i = '1; auto_req_i = '1;
        cyc("R5"); cyc("R5");
        // R2: disabled channels with self request
        src_sel_i = '0; ch_en_i = '0;
        cyc("R2");
        ch_en_i[11] = 1'b1;
        cyc("R2");
        drain("R10");

        // R6: fixed order keeps choosing channel 0
        ch_en_i = '1; auto_req_i = '1; rr_mode_i = 1'b0;
        for (int r = 0; r < 4; r++) begin
            done_i = '0; cyc("R6");
            done_i = '1; cyc("R6");
            done_i = '0;
        end
        drain("R10");

        // R7: rotating order walks every channel
        ch_en_i = '1; auto_req_i = '1; rr_mode_i = 1'b1;
        for (int r = 0; r < 14; r++) begin
            done_i = '0; cyc("R7");
            done_i = '1; cyc("R7");
        end
        drain("R10");

        // R9: hold against other done bits and mode/request changes
        ch_en_i = 12'h100; auto_req_i = '1;
        cyc("R8");
        done_i = 12'hEFF; rr_mode_i = 1'b0; ch_en_i = '1;
        cyc("R9"); cyc("R9");
        done_i = 12'h100;
        cyc("R10");
        done_i = '0;
        cyc("R10");
        drain("R10");

        // R8: seeded random traffic
        for (int t = 0; t < 4000; t++) begin
            ch_en_i    = 12'($urandom) | 12'($urandom);
            src_sel_i  = 24'($urandom);
            ext_req_i  = 4'($urandom);
            peri_req_i = 6'($urandom);
            auto_req_i = 12'($urandom);
            done_i     = 12'($urandom) & 12'($urandom) & 12'($urandom);
            if (($urandom % 16) == 0) rr_mode_i = ~rr_mode_i;
            cyc("R8");
        end

        if (wd_hit) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: expired expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : wd_end
        wait (wd_hit);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule